// File: doc/BRIEF.md
# Multi-Mode Shift Register

A clocked register that, on each rising edge, either takes a new value from a parallel data input, holds its contents, or moves its contents by one bit position. Six single-step moves are offered: rotate right, rotate left, zero-fill right, zero-fill left, sign-keeping right, and arithmetic left. The arithmetic left move also reports whether the signed value has changed sign, through a registered overflow flag.

The move is chosen by a 3-bit operation code. A load strobe takes priority over the code. A synchronous active-high reset clears the register and the flag. The width of the register is a parameter, with a default of 8.

Top module: `shift_unit`

## Requirements
- R1: While reset is high at a rising edge, the register value and the overflow flag become zero.
- R2: When load is high, the register takes the value on loadData at the next edge, whatever the opcode is, and the overflow flag clears.
- R3: Opcodes 000 and 111 hold the register value, and the overflow flag clears.
- R4: Opcode 001 rotates the register right by one bit, and the old bit 0 goes to the top bit (10010101 becomes 11001010).
- R5: Opcode 010 rotates the register left by one bit, and the old top bit goes to bit 0.
- R6: Opcode 011 shifts the register right by one bit and puts a zero in the top bit.
- R7: Opcode 100 shifts the register left by one bit and puts a zero in bit 0.
- R8: Opcode 101 shifts the register right by one bit and copies the old top bit into the top bit (11001010 becomes 11100101).
- R9: Opcode 110 shifts the register left by one bit and puts a zero in bit 0. The overflow flag is set when the old top two bits differ and cleared when they match.
- R10: Every opcode other than 110 clears the overflow flag, and so does a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opCode | input | 3 | Selects the operation |
| load | input | 1 | Parallel load strobe; overrides opCode |
| loadData | input | WIDTH | Parallel load value |
| shiftOut | output | WIDTH | Register contents |
| overflow | output | 1 | Arithmetic left-shift sign-change flag |

## Verification
The bench uses the default width of 8. At that width every one of the 256 start values can be paired with every one of the 8 opcodes, which gives a complete sweep of 2048 cases, and each expected result is worked out arithmetically in the bench. The six-step sequence that starts from 10010101 is also replayed, and load priority is checked against every opcode.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;
  typedef enum logic [2:0] {
    OP_HOLD0 = 3'b000,
    OP_ROR   = 3'b001,
    OP_ROL   = 3'b010,
    OP_LSR   = 3'b011,
    OP_LSL   = 3'b100,
    OP_ASR   = 3'b101,
    OP_ASL   = 3'b110,
    OP_HOLD1 = 3'b111
  } shiftOp_e;

  typedef enum logic [1:0] {
    FILL_ZERO,
    FILL_WRAP,
    FILL_SIGN
  } fillSel_e;

  typedef struct packed {
    logic     doLoad;
    logic     doShift;
    logic     dirLeft;
    fillSel_e fill;
    logic     checkOvf;
  } shiftCtrl_t;
endpackage

// File: rtl/shift_unit_ctrl.sv
module shift_unit_ctrl
  import shift_unit_pkg::*;
(
  input  logic       load,
  input  logic [2:0] opCode,
  output shiftCtrl_t ctrl
);
  always_comb begin
    ctrl = '{doLoad: 1'b0, doShift: 1'b0, dirLeft: 1'b0,
             fill: FILL_ZERO, checkOvf: 1'b0};
    if (load) begin
      ctrl.doLoad = 1'b1;
    end else begin
      unique case (shiftOp_e'(opCode))
        OP_ROR: begin ctrl.doShift = 1'b1; ctrl.fill = FILL_WRAP; end
        OP_ROL: begin ctrl.doShift = 1'b1; ctrl.dirLeft = 1'b1; ctrl.fill = FILL_WRAP; end
        OP_LSR: begin ctrl.doShift = 1'b1; end
        OP_LSL: begin ctrl.doShift = 1'b1; ctrl.dirLeft = 1'b1; end
        OP_ASR: begin ctrl.doShift = 1'b1; ctrl.fill = FILL_SIGN; end
        OP_ASL: begin ctrl.doShift = 1'b1; ctrl.dirLeft = 1'b1; ctrl.checkOvf = 1'b1; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/shift_unit_dp.sv
module shift_unit_dp
  import shift_unit_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  shiftCtrl_t       ctrl,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] regQ,
  output logic             ovfQ
);
  localparam int MSB = WIDTH - 1;

  logic             fillBit;
  logic [WIDTH-1:0] shifted;
  logic             ovfNext;

  always_comb begin
    unique case (ctrl.fill)
      FILL_WRAP: fillBit = ctrl.dirLeft ? regQ[MSB] : regQ[0];
      FILL_SIGN: fillBit = regQ[MSB];
      default:   fillBit = 1'b0;
    endcase
    if (ctrl.dirLeft) shifted = {regQ[MSB-1:0], fillBit};
    else              shifted = {fillBit, regQ[MSB:1]};
    ovfNext = ctrl.checkOvf & (regQ[MSB] ^ regQ[MSB-1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regQ <= '0;
      ovfQ <= 1'b0;
    end else begin
      if (ctrl.doLoad)       regQ <= loadData;
      else if (ctrl.doShift) regQ <= shifted;
      ovfQ <= ovfNext;
    end
  end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_unit_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       opCode,
  input  logic             load,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] shiftOut,
  output logic             overflow
);
  shiftCtrl_t ctrl;

  shift_unit_ctrl i_ctrl (
    .load   (load),
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  shift_unit_dp #(.WIDTH(WIDTH)) i_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .loadData (loadData),
    .regQ     (shiftOut),
    .ovfQ     (overflow)
  );
endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       opCode,
  input logic             load,
  input logic [WIDTH-1:0] loadData,
  input logic [WIDTH-1:0] shiftOut,
  input logic             overflow
);
  localparam int MSB = WIDTH - 1;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (shiftOut == '0 && !overflow));

  a_r2_load_value: assert property (@(posedge clk) disable iff (rst)
    load |=> (shiftOut == $past(loadData) && !overflow));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!load && (opCode == 3'b000 || opCode == 3'b111)) |=> $stable(shiftOut));

  a_r4_rotate_right: assert property (@(posedge clk) disable iff (rst)
    (!load && opCode == 3'b001) |=>
      shiftOut == {$past(shiftOut[0]), $past(shiftOut[MSB:1])});

  a_r8_sign_keep: assert property (@(posedge clk) disable iff (rst)
    (!load && opCode == 3'b101) |=> shiftOut[MSB] == $past(shiftOut[MSB]));

  a_r9_overflow: assert property (@(posedge clk) disable iff (rst)
    (!load && opCode == 3'b110) |=>
      overflow == ($past(shiftOut[MSB]) ^ $past(shiftOut[MSB-1])));

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (load || opCode != 3'b110) |=> !overflow);
endmodule

bind shift_unit shift_unit_chk #(.WIDTH(WIDTH)) i_chk (.*);

// File: tb/test_shift_unit.sv
module test_shift_unit;
  localparam int WIDTH = 8;
  localparam time CLK_PERIOD = 10ns;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       opCode = 3'b000;
  logic             load = 1'b0;
  logic [WIDTH-1:0] loadData = '0;
  logic [WIDTH-1:0] shiftOut;
  logic             overflow;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_unit #(.WIDTH(WIDTH)) i_shift_unit (.*);

  task automatic check(input string req, input logic [WIDTH-1:0] expV,
                       input logic expO);
    checks++;
    if (shiftOut !== expV || overflow !== expO) begin
      fails++;
      $display("FAIL %s: got %b ovf %b, expected %b ovf %b",
               req, shiftOut, overflow, expV, expO);
    end
  endtask

  // Drive on the falling edge, step over one rising edge, sample on the next falling edge.
  task automatic step(input logic ld, input logic [2:0] op, input logic [WIDTH-1:0] d);
    load = ld; opCode = op; loadData = d;
    @(negedge clk);
  endtask

  function automatic logic [WIDTH:0] model(input logic [WIDTH-1:0] v, input logic [2:0] op);
    logic [WIDTH-1:0] r;
    logic o;
    o = 1'b0;
    case (op)
      3'b001: r = (v >> 1) | (v << (WIDTH-1));
      3'b010: r = (v << 1) | (v >> (WIDTH-1));
      3'b011: r = v >> 1;
      3'b100: r = v << 1;
      3'b101: r = (v >> 1) | (v & (1 << (WIDTH-1)));
      3'b110: begin r = v << 1; o = v[WIDTH-1] ^ v[WIDTH-2]; end
      default: r = v;
    endcase
    return {o, r};
  endfunction

  function automatic string reqOf(input logic [2:0] op);
    case (op)
      3'b001: return "R4";
      3'b010: return "R5";
      3'b011: return "R6";
      3'b100: return "R7";
      3'b101: return "R8";
      3'b110: return "R9";
      default: return "R3";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [WIDTH:0] e;
    @(negedge clk);
    @(negedge clk);
    check("R1", '0, 1'b0);
    rst = 1'b0;

    // Fixed sequence starting from 10010101
    step(1'b1, 3'b000, 8'b10010101); check("R2", 8'b10010101, 1'b0);
    step(1'b0, 3'b001, '0); check("R4", 8'b11001010, 1'b0);
    step(1'b0, 3'b101, '0); check("R8", 8'b11100101, 1'b0);
    step(1'b0, 3'b100, '0); check("R7", 8'b11001010, 1'b0);
    step(1'b0, 3'b011, '0); check("R6", 8'b01100101, 1'b0);
    step(1'b0, 3'b010, '0); check("R5", 8'b11001010, 1'b0);
    step(1'b0, 3'b110, '0); check("R9", 8'b10010100, 1'b0);
    step(1'b0, 3'b110, '0); check("R9", 8'b00101000, 1'b1);
    step(1'b0, 3'b000, '0); check("R10", 8'b00101000, 1'b0);

    // Exhaustive sweep: every value with every opcode
    for (int v = 0; v < (1 << WIDTH); v++) begin
      for (int op = 0; op < 8; op++) begin
        step(1'b1, 3'b000, WIDTH'(v));
        e = model(WIDTH'(v), 3'(op));
        step(1'b0, 3'(op), '0);
        check(reqOf(3'(op)), e[WIDTH-1:0], e[WIDTH]);
      end
    end

    // R2: load wins over every opcode, and load clears the flag (R10)
    for (int op = 0; op < 8; op++) begin
      step(1'b1, 3'b000, 8'b01000000);
      step(1'b0, 3'b110, '0);
      check("R9", 8'b10000000, 1'b1);
      step(1'b1, 3'(op), 8'h5A);
      check("R2", 8'h5A, 1'b0);
    end

    // R10: non-arithmetic-left ops clear a set flag
    for (int op = 0; op < 8; op++) begin
      if (op == 6) continue;
      step(1'b1, 3'b000, 8'b01000001);
      step(1'b0, 3'b110, '0);
      e = model(8'b01000001, 3'(op) == 3'b000 ? 3'b000 : 3'(op));
      e = model(8'b10000010, 3'(op));
      step(1'b0, 3'(op), '0);
      check("R10", e[WIDTH-1:0], 1'b0);
    end

    // R1: reset in mid-run clears everything
    step(1'b1, 3'b000, 8'hFF);
    rst = 1'b1;
    step(1'b0, 3'b110, '0);
    check("R1", '0, 1'b0);
    rst = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule